// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is a standard-mode two-wire serial slave that holds the configuration bytes of a system clock generator. Both bus lines are sampled on a fast system clock, so the slave never runs on the bus clock. Its open-drain data output is a single "pull low" request. It does not stretch the clock and does not arbitrate.

A write at address byte D2h carries two header bytes and then the configuration bytes. The header bytes stand for a command code and a byte count. The slave acknowledges both and then drops them, so there is no register pointer. Every write starts at configuration byte 0 and moves upward one byte at a time. A read at address byte D3h first returns a byte count of 07h and then the seven configuration bytes, lowest first. The register contents drive the spread-spectrum controls, the output tri-state, a software frequency override and the per-output enable masks of the clock generator.

The state machine uses these states:
- IDLE: bus free.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- WR_BYTE: shifting in a write byte.
- WR_ACK: acknowledging a write byte.
- RD_BYTE: shifting out a read byte.
- RD_ACK: sampling the master's acknowledge.
- DROP: ignoring the bus until the next start or stop.

The transitions are:
- A stop moves any state to IDLE.
- A start moves any state to ADDR.
- At the eighth SCL fall, ADDR goes to ADDR_ACK on an address match, or to DROP otherwise.
- At the next SCL fall, ADDR_ACK goes to WR_BYTE for a write or to RD_BYTE for a read.
- At the eighth SCL fall, WR_BYTE goes to WR_ACK.
- At the following SCL fall, WR_ACK goes back to WR_BYTE.
- At the eighth SCL fall, RD_BYTE goes to RD_ACK.
- At the next SCL fall, RD_ACK goes back to RD_BYTE if the master acknowledged, or to DROP if it did not.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, configuration byte 0 is 00h and bytes 1 to 6 are FFh. As a result all exported controls are 0 and all enable masks are 1.
- R2: The slave acknowledges only the address bytes D2h (write) and D3h (read). For any other address it drives no acknowledge and no data, and the bytes that follow change no register, until the next start or stop.
- R3: In a write, the two bytes after the address are acknowledged and leave every register unchanged.
- R4: The third and later written bytes land in bytes 0, 1, 2 and onward, in that order. Byte 0 maps as follows:
  - bit 7 drives `cfg_spread_wide`;
  - bit 1 drives `cfg_spread_en`;
  - bit 0 drives `cfg_hiz`;
  - bit 3 drives `cfg_freq_sw`;
  - `cfg_freq_code` is {bit 2, bits 6:4}.
  
  Bytes 1 to 5 appear on `cfg_en_mask`, with byte 1 in bits 7:0 and byte 5 in bits 39:32.
- R5: Written bytes beyond byte 5 are acknowledged and discarded. Byte 6 is read-only and stays FFh.
- R6: A stop after any complete byte keeps the bytes already written and leaves the later bytes unchanged.
- R7: A read returns 07h, then bytes 0 to 6, then FFh for any further byte. Each new byte follows a master acknowledge. After a master not-acknowledge, the slave releases SDA until the next start or stop.
- R8: A repeated start inside a write restarts the sequence, so the next data byte after the new header goes to byte 0 again.
- R9: The slave starts pulling SDA low only while the sampled SCL is low. It releases SDA in the cycle after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, asynchronous |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_low | output | 1 | 1 = drive SDA low, 0 = release |
| cfg_spread_en | output | 1 | Center spread enabled (byte 0 bit 1) |
| cfg_spread_wide | output | 1 | Wide spread depth (byte 0 bit 7) |
| cfg_hiz | output | 1 | Tri-state all clock outputs (byte 0 bit 0) |
| cfg_freq_sw | output | 1 | Frequency taken from the register, not the pins (byte 0 bit 3) |
| cfg_freq_code | output | 4 | Register frequency code {bit 2, bits 6:4} |
| cfg_en_mask | output | 40 | Output enable masks, bytes 5..1 |

## Verification
Every bus event reaches the state machine three system clocks after the pin changes: two synchronizer stages plus one edge-detect flop. A written byte therefore shows on the configuration outputs right after the third rising clock edge that follows the eighth SCL fall. The reference model in the bench updates exactly at that edge, and the outputs are compared with it on every falling clock edge. Acknowledge and read-data bits are sampled in the middle of the SCL high phase. That point lies well after the three-cycle latency of the slave's drive and well before the next SCL fall.

// File: rtl/clkcfg_i2c_pkg.sv
package clkcfg_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_DROP
    } bus_state_e;

endpackage

// File: rtl/clkcfg_bus_sync.sv
module clkcfg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe    <= '1;
                prev[g] <= 1'b1;
            end else begin
                pipe    <= {pipe[STAGES-2:0], raw[g]};
                prev[g] <= pipe[STAGES-1];
            end
        end
        assign lvl[g] = pipe[STAGES-1];
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~prev[0];
    assign scl_fall  = ~lvl[0] & prev[0];
    assign start_evt = lvl[0] & prev[0] & prev[1] & ~lvl[1];
    assign stop_evt  = lvl[0] & prev[0] & ~prev[1] & lvl[1];

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
    parameter int NUM_BYTES = 7,
    parameter int NUM_WR    = 6,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [8*NUM_BYTES-1:0] regs_flat
);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        logic [7:0] val;
        if (k < NUM_WR) begin : g_rw
            localparam logic [7:0] RST_VAL = (k == 0) ? 8'h00 : 8'hFF;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val <= RST_VAL;
                end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                    val <= wr_data;
                end
            end
        end else begin : g_ro
            assign val = 8'hFF;
        end
        assign regs_flat[8*k +: 8] = val;
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data = regs_flat[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_BYTES   = 7,
    parameter int         NUM_WR      = 6,
    parameter int         HDR_BYTES   = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_pull_low,
    output logic                      cfg_spread_en,
    output logic                      cfg_spread_wide,
    output logic                      cfg_hiz,
    output logic                      cfg_freq_sw,
    output logic [3:0]                cfg_freq_code,
    output logic [8*(NUM_WR-1)-1:0]   cfg_en_mask
);

    localparam int IDX_W   = $clog2(NUM_BYTES + 1);
    localparam int CNT_W   = $clog2(HDR_BYTES + NUM_WR + 2);
    localparam int RP_W    = $clog2(NUM_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HDR_BYTES + NUM_WR);
    localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_BYTES);
    localparam logic [RP_W-1:0]  RP_MAX  = RP_W'(NUM_BYTES + 1);
    localparam logic [7:0]       COUNT_BYTE = 8'(NUM_BYTES);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    clkcfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    bus_state_e        state_q, state_d;
    logic [3:0]        bit_cnt_q;
    logic [7:0]        shreg_q;
    logic [7:0]        tx_q;
    logic              rw_q;
    logic              mst_ack_q;
    logic [CNT_W-1:0]  wr_cnt_q;
    logic [RP_W-1:0]   rd_ptr_q;

    logic              bit_full;
    logic              addr_hit;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_data;
    logic [8*NUM_BYTES-1:0] regs_flat;
    logic [7:0]        byte0;

    assign bit_full = (bit_cnt_q == 4'd8);
    assign addr_hit = (shreg_q[7:1] == DEV_ADDR);
    assign wr_en    = (state_q == ST_WR_BYTE) && scl_fall && bit_full &&
                      (wr_cnt_q >= CNT_HDR) && (wr_cnt_q < CNT_MAX);
    assign wr_idx   = IDX_W'(wr_cnt_q - CNT_HDR);
    assign rd_idx   = IDX_W'(rd_ptr_q - RP_W'(1));

    clkcfg_regfile #(
        .NUM_BYTES (NUM_BYTES),
        .NUM_WR    (NUM_WR),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (shreg_q),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DROP: state_d = state_q;
                ST_ADDR: if (scl_fall && bit_full)
                             state_d = addr_hit ? ST_ADDR_ACK : ST_DROP;
                ST_ADDR_ACK: if (scl_fall)
                             state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE: if (scl_fall && bit_full) state_d = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE: if (scl_fall && bit_cnt_q == 4'd7) state_d = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall)
                             state_d = mst_ack_q ? ST_RD_BYTE : ST_DROP;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            tx_q      <= 8'hFF;
            rw_q      <= 1'b0;
            mst_ack_q <= 1'b0;
            wr_cnt_q  <= '0;
            rd_ptr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start_evt) begin
                bit_cnt_q <= '0;
                wr_cnt_q  <= '0;
                rd_ptr_q  <= '0;
            end else if (!stop_evt) begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise && !bit_full) begin
                            shreg_q   <= {shreg_q[6:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end
                        if (scl_fall && bit_full) begin
                            if (state_q == ST_ADDR) begin
                                rw_q <= shreg_q[0];
                            end else if (wr_cnt_q < CNT_MAX) begin
                                wr_cnt_q <= wr_cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                tx_q     <= COUNT_BYTE;
                                rd_ptr_q <= RP_W'(1);
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) bit_cnt_q <= '0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            tx_q      <= {tx_q[6:0], 1'b1};
                            bit_cnt_q <= (bit_cnt_q == 4'd7) ? 4'd0 : bit_cnt_q + 4'd1;
                            mst_ack_q <= 1'b0;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mst_ack_q <= ~sda_lvl;
                        if (scl_fall && mst_ack_q) begin
                            tx_q <= rd_data;
                            if (rd_ptr_q < RP_MAX) rd_ptr_q <= rd_ptr_q + RP_W'(1);
                        end
                    end
                    ST_IDLE, ST_DROP: ;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_low = 1'b1;
            ST_RD_BYTE:             sda_pull_low = ~tx_q[7];
            default:                sda_pull_low = 1'b0;
        endcase
    end

    assign byte0           = regs_flat[7:0];
    assign cfg_spread_wide = byte0[7];
    assign cfg_spread_en   = byte0[1];
    assign cfg_hiz         = byte0[0];
    assign cfg_freq_sw     = byte0[3];
    assign cfg_freq_code   = {byte0[2], byte0[6:4]};
    assign cfg_en_mask     = regs_flat[8*NUM_WR-1:8];

endmodule

// File: rtl/clkcfg_i2c_checks.sv
module clkcfg_i2c_checks
    import clkcfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       stop_evt,
    input logic       sda_pull_low,
    input bus_state_e state_q,
    input logic [7:0] shreg_q,
    input logic       wr_en,
    input logic [7:0] byte0
);

    assert_pull_only_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_lvl);

    assert_release_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_low);

    assert_ack_only_own_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) |-> (shreg_q[7:1] == DEV_ADDR));

    assert_cfg_moves_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte0) |-> $past(wr_en));

    assert_drop_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |=> (state_q != ST_DROP) || !sda_pull_low);

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checks #(.DEV_ADDR(DEV_ADDR)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_lvl      (scl_lvl),
    .stop_evt     (stop_evt),
    .sda_pull_low (sda_pull_low),
    .state_q      (state_q),
    .shreg_q      (shreg_q),
    .wr_en        (wr_en),
    .byte0        (byte0)
);

// File: tb/test_clkcfg_i2c_slave.sv
module test_clkcfg_i2c_slave;

    localparam int HALF = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low;
    logic sda_bus;
    logic cfg_spread_en, cfg_spread_wide, cfg_hiz, cfg_freq_sw;
    logic [3:0]  cfg_freq_code;
    logic [39:0] cfg_en_mask;

    assign sda_bus = sda_m & ~sda_pull_low;

    clkcfg_i2c_slave i_clkcfg_i2c_slave (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_bus),
        .sda_pull_low    (sda_pull_low),
        .cfg_spread_en   (cfg_spread_en),
        .cfg_spread_wide (cfg_spread_wide),
        .cfg_hiz         (cfg_hiz),
        .cfg_freq_sw     (cfg_freq_sw),
        .cfg_freq_code   (cfg_freq_code),
        .cfg_en_mask     (cfg_en_mask)
    );

    int errs = 0;
    int checks = 0;
    logic [7:0] ref_b [7];
    bit live = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_fields();
        logic [39:0] m;
        for (int k = 1; k <= 5; k++) m[8*(k-1) +: 8] = ref_b[k];
        return {16'h0, ref_b[0][7], ref_b[0][1], ref_b[0][0], ref_b[0][3],
                ref_b[0][2], ref_b[0][6:4], m};
    endfunction

    function automatic logic [63:0] act_fields();
        return {16'h0, cfg_spread_wide, cfg_spread_en, cfg_hiz, cfg_freq_sw,
                cfg_freq_code, cfg_en_mask};
    endfunction

    // cycle-by-cycle comparison with the reference model (R4 field map)
    always @(negedge clk) begin
        if (live && !done) check(act_fields() == exp_fields(), "R4", "config outputs",
                                 act_fields(), exp_fields());
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input int slot, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0;
            if (i > 0) tick(2);
        end
        if (slot >= 0) begin
            repeat (3) @(posedge clk);
            ref_b[slot] = b;
        end
        tick(2);
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF / 2);
        check(sda_bus == !exp_ack, req, "acknowledge bit", 64'(sda_bus), 64'(!exp_ack));
        tick(HALF - HALF / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
        logic [7:0] got;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl_m = 1'b1; tick(HALF / 2);
            got[i] = sda_bus;
            tick(HALF - HALF / 2);
            scl_m = 1'b0; tick(2);
        end
        check(got == exp, req, "read byte", 64'(got), 64'(exp));
        sda_m = mack ? 1'b0 : 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] read_exp(input int k);
        if (k == 0) return 8'h07;
        if (k <= 7) return ref_b[k-1];
        return 8'hFF;
    endfunction

    task automatic read_all(input string req);
        bus_start();
        send_byte(8'hD3, 1'b1, -1, req);
        for (int k = 0; k < 9; k++) recv_byte(read_exp(k), k < 8, req);
        tick(5);
        check(!sda_pull_low, "R7", "released after master nack", 64'(sda_pull_low), 64'(0));
        bus_stop();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ref_b[0] = 8'h00;
        for (int k = 1; k < 7; k++) ref_b[k] = 8'hFF;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        check(act_fields() == exp_fields(), "R1", "reset defaults", act_fields(), exp_fields());
        check(!sda_pull_low, "R1", "sda released after reset", 64'(sda_pull_low), 64'(0));
        live = 1'b1;

        // R3 header discarded, R4 data into bytes 0/1, R6 stop after byte 1
        bus_start();
        send_byte(8'hD2, 1'b1, -1, "R2");
        send_byte(8'h55, 1'b1, -1, "R3");
        send_byte(8'h99, 1'b1, -1, "R3");
        send_byte(8'h8B, 1'b1, 0, "R4");
        send_byte(8'h0F, 1'b1, 1, "R4");
        bus_stop();
        tick(3);
        check(!sda_pull_low, "R9", "released after stop", 64'(sda_pull_low), 64'(0));
        read_all("R6");

        // R2: foreign address gets no ack and no effect
        bus_start();
        send_byte(8'hA2, 1'b0, -1, "R2");
        send_byte(8'h00, 1'b0, -1, "R2");
        send_byte(8'h00, 1'b0, -1, "R2");
        send_byte(8'h00, 1'b0, -1, "R2");
        bus_stop();

        // R5: full write with overflow bytes acked but dropped
        bus_start();
        send_byte(8'hD2, 1'b1, -1, "R2");
        send_byte(8'h00, 1'b1, -1, "R3");
        send_byte(8'h06, 1'b1, -1, "R3");
        send_byte(8'h74, 1'b1, 0, "R4");
        send_byte(8'h11, 1'b1, 1, "R4");
        send_byte(8'h22, 1'b1, 2, "R4");
        send_byte(8'h33, 1'b1, 3, "R4");
        send_byte(8'h44, 1'b1, 4, "R4");
        send_byte(8'h55, 1'b1, 5, "R4");
        send_byte(8'hAA, 1'b1, -1, "R5");
        send_byte(8'hBB, 1'b1, -1, "R5");
        bus_stop();
        read_all("R5");

        // R8: repeated start restarts at byte 0
        bus_start();
        send_byte(8'hD2, 1'b1, -1, "R8");
        send_byte(8'h01, 1'b1, -1, "R3");
        send_byte(8'h02, 1'b1, -1, "R3");
        send_byte(8'h01, 1'b1, 0, "R8");
        send_byte(8'h66, 1'b1, 1, "R8");
        bus_start();
        send_byte(8'hD2, 1'b1, -1, "R8");
        send_byte(8'h01, 1'b1, -1, "R3");
        send_byte(8'h02, 1'b1, -1, "R3");
        send_byte(8'h83, 1'b1, 0, "R8");
        bus_stop();
        read_all("R8");

        tick(10);
        finish_run();
    end

endmodule